// File: doc/BRIEF.md
# Real-Time-Clock Control Register and Interrupt Gate

This block keeps the eight control bits of a real-time clock. It turns them into three things: an active-low interrupt request, a gated square-wave output and an update-inhibit level. A byte-wide host port writes the register and reads it back. Three event flags come in from the surrounding clock logic: periodic, alarm and update-ended. Each flag can assert the interrupt only while its own enable bit is set. A separate rate clock feeds the square-wave output, which is held low unless its enable is set.

The control bits do not share one reset rule. The four interrupt and square-wave enables are cleared when the active-low reset pin is sampled low. The update-inhibit bit, the data-format bit, the hour-format bit and the daylight-saving enable keep their values through reset. They change only when the host writes them. Writing the inhibit bit from 0 to 1 also clears the update-ended enable, whatever value is written to that bit.

Top module: `rtc_ctrl_gate`

## Requirements
- R1: When `wr_en` is high at a rising `clk` edge with `rst_n` high, the register takes the value `wr_data`, except as R4 describes. `rd_data` always shows the current register value, and reading has no side effects.
- R2: When `rst_n` is low at a rising edge, bits 6 (periodic enable), 5 (alarm enable), 4 (update-ended enable) and 3 (square-wave enable) become 0. Bits 7 (inhibit), 2 (data format), 1 (hour format) and 0 (daylight-saving enable) keep their values when no write is present.
- R3: When a write and a low `rst_n` fall on the same edge, bits 7, 2, 1 and 0 take the written value and bits 6 to 3 become 0.
- R4: A write that takes bit 7 from 0 to 1 leaves bit 4 at 0, whatever value is written to bit 4. A write while bit 7 is already 1 loads bit 4 from `wr_data` as usual.
- R5: `irq_n` is low in the same cycle whenever at least one enabled flag is set. The pairs are `flag_periodic` with bit 6, `flag_alarm` with bit 5 and `flag_update` with bit 4. Otherwise `irq_n` is high.
- R6: A flag whose enable bit is 0 has no effect on `irq_n`. This holds for every combination of flags and enables.
- R7: `sq_out` equals `sq_src` while bit 3 is 1 and is 0 while bit 3 is 0.
- R8: `upd_inhibit` mirrors bit 7. `bin_mode` mirrors bit 2 (1 = binary, 0 = BCD). `hr24_mode` mirrors bit 1 (1 = 24-hour, 0 = 12-hour). `dst_en` mirrors bit 0.
- R9: With `rst_n` high and `wr_en` low, the register keeps its value. No flag or square-wave activity changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset pin, sampled on `clk` |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Current register contents |
| flag_periodic | input | 1 | Periodic event flag |
| flag_alarm | input | 1 | Alarm match flag |
| flag_update | input | 1 | Update-ended flag |
| sq_src | input | 1 | Selected rate clock for the square wave |
| irq_n | output | 1 | Active-low interrupt request |
| sq_out | output | 1 | Gated square-wave output |
| upd_inhibit | output | 1 | Suppresses the once-per-second update transfer |
| bin_mode | output | 1 | Binary (1) or BCD (0) time data |
| hr24_mode | output | 1 | 24-hour (1) or 12-hour (0) format |
| dst_en | output | 1 | Daylight-saving adjustment enable |

## Verification
The assertions assume that `rst_n`, `wr_en`, `wr_data` and the three flags are synchronous to `clk`. They also assume these inputs never carry unknown values at an edge, and that the first reset cycle loads the bits that reset does not clear. The bench respects these assumptions. It changes every input only on the falling edge and writes a known byte while the reset pin is still low. It also treats `sq_src` as a plain level, so the combinational gating is checked half a cycle away from any register update.

// File: rtl/rtc_ctrl_gate.sv
module rtc_ctrl_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          flag_periodic,
  input  logic          flag_alarm,
  input  logic          flag_update,
  input  logic          sq_src,
  output logic          irq_n,
  output logic          sq_out,
  output logic          upd_inhibit,
  output logic          bin_mode,
  output logic          hr24_mode,
  output logic          dst_en
);
  localparam int B_INH = 7;
  localparam int B_PEN = 6;
  localparam int B_AEN = 5;
  localparam int B_UEN = 4;
  localparam int B_SQE = 3;
  localparam int B_BIN = 2;
  localparam int B_H24 = 1;
  localparam int B_DST = 0;

  logic [DW-1:0] ctrl, nxt;

  always_comb begin
    nxt = wr_data;
    if (wr_data[B_INH] && !ctrl[B_INH]) nxt[B_UEN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (wr_en) begin
        ctrl[B_INH] <= wr_data[B_INH];
        ctrl[B_BIN] <= wr_data[B_BIN];
        ctrl[B_H24] <= wr_data[B_H24];
        ctrl[B_DST] <= wr_data[B_DST];
      end
      ctrl[B_PEN] <= 1'b0;
      ctrl[B_AEN] <= 1'b0;
      ctrl[B_UEN] <= 1'b0;
      ctrl[B_SQE] <= 1'b0;
    end else if (wr_en) begin
      ctrl <= nxt;
    end
  end

  assign rd_data     = ctrl;
  assign irq_n       = !((flag_periodic && ctrl[B_PEN]) ||
                         (flag_alarm    && ctrl[B_AEN]) ||
                         (flag_update   && ctrl[B_UEN]));
  assign sq_out      = sq_src && ctrl[B_SQE];
  assign upd_inhibit = ctrl[B_INH];
  assign bin_mode    = ctrl[B_BIN];
  assign hr24_mode   = ctrl[B_H24];
  assign dst_en      = ctrl[B_DST];

  p_rst_clears_r2: assert property (@(posedge clk)
    !rst_n |=> (rd_data[B_PEN:B_SQE] == 4'b0000));
  p_rst_keeps_r2: assert property (@(posedge clk)
    (!rst_n && !wr_en) |=> ($stable(rd_data[B_INH]) && $stable(rd_data[B_BIN:B_DST])));
  p_uen_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_inhibit) |-> !rd_data[B_UEN]);
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_PEN:B_UEN] == 3'b000) |-> irq_n);
  p_irq_periodic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_periodic && rd_data[B_PEN]) |-> !irq_n);
  p_sq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_SQE] |-> !sq_out);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !wr_en) |=> $stable(rd_data));
endmodule

// File: tb/test_rtc_ctrl_gate.sv
module test_rtc_ctrl_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic fp = 1'b0, fa = 1'b0, fu = 1'b0, sq = 1'b0;
  logic [7:0] rd_data;
  logic irq_n, sq_out, upd_inhibit, bin_mode, hr24_mode, dst_en;
  logic [7:0] mdl = 8'h00;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rtc_ctrl_gate i_rtc_ctrl_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .flag_periodic(fp), .flag_alarm(fa), .flag_update(fu), .sq_src(sq),
    .irq_n(irq_n), .sq_out(sq_out), .upd_inhibit(upd_inhibit),
    .bin_mode(bin_mode), .hr24_mode(hr24_mode), .dst_en(dst_en)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic exp_irq;
    exp_irq = !((fp && mdl[6]) || (fa && mdl[5]) || (fu && mdl[4]));
    chk(tag, "rd_data", rd_data, mdl);
    chk(tag, "irq_n", irq_n, exp_irq);
    chk(tag, "sq_out", sq_out, sq && mdl[3]);
    chk(tag, "mirrors", {upd_inhibit, bin_mode, hr24_mode, dst_en},
        {mdl[7], mdl[2], mdl[1], mdl[0]});
  endtask

  task automatic cyc(input logic r, input logic we, input logic [7:0] wd,
                     input logic [2:0] flags, input logic s, input string tag);
    logic [7:0] n;
    @(negedge clk);
    rst_n = r; wr_en = we; wr_data = wd;
    {fp, fa, fu} = flags; sq = s;
    #1 compare(tag);
    @(posedge clk);
    if (!r) begin
      if (we) begin mdl[7] = wd[7]; mdl[2:0] = wd[2:0]; end
      mdl[6:3] = 4'b0000;
    end else if (we) begin
      n = wd;
      if (wd[7] && !mdl[7]) n[4] = 1'b0;
      mdl = n;
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(1'b0, 1'b1, 8'h7E, 3'b000, 1'b0, "R3");
    cyc(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, "R3");
    chk("R3", "rd_data after reset write", rd_data, 8'h06);
    cyc(1'b1, 1'b1, 8'h78, 3'b000, 1'b0, "R1");
    cyc(1'b1, 1'b0, 8'h00, 3'b100, 1'b1, "R5");
    chk("R1", "rd_data after write", rd_data, 8'h78);
    cyc(1'b1, 1'b0, 8'h00, 3'b010, 1'b0, "R5");
    cyc(1'b1, 1'b0, 8'h00, 3'b001, 1'b1, "R7");
    for (int e = 0; e < 8; e++) begin
      cyc(1'b1, 1'b1, {1'b0, e[2:0], 4'b0110}, 3'b000, 1'b0, "R6");
      for (int f = 0; f < 8; f++)
        cyc(1'b1, 1'b0, 8'h00, f[2:0], f[0], "R6");
    end
    cyc(1'b1, 1'b1, 8'h00, 3'b000, 1'b0, "R4");
    cyc(1'b1, 1'b1, 8'hF8, 3'b001, 1'b0, "R4");
    cyc(1'b1, 1'b0, 8'h00, 3'b001, 1'b0, "R4");
    chk("R4", "uen after inhibit rise", rd_data, 8'hE8);
    cyc(1'b1, 1'b1, 8'hF8, 3'b001, 1'b0, "R4");
    cyc(1'b1, 1'b0, 8'h00, 3'b001, 1'b0, "R4");
    chk("R4", "uen with inhibit held", rd_data, 8'hF8);
    cyc(1'b1, 1'b1, 8'hFF, 3'b000, 1'b0, "R8");
    cyc(1'b0, 1'b0, 8'h00, 3'b111, 1'b1, "R2");
    cyc(1'b1, 1'b0, 8'h00, 3'b111, 1'b1, "R2");
    chk("R2", "rd_data after reset pulse", rd_data, 8'h87);
    for (int k = 0; k < 6; k++)
      cyc(1'b1, 1'b0, 8'h00, 3'(k), k[0], "R9");
    cyc(1'b1, 1'b1, 8'h08, 3'b000, 1'b0, "R7");
    for (int k = 0; k < 8; k++)
      cyc(1'b1, 1'b0, 8'h00, 3'b000, k[0], "R7");
    for (int k = 0; k < 400; k++) begin
      int rv;
      rv = $urandom;
      cyc((rv[3:0] != 0), (rv[6:4] == 0), rv[15:8], rv[18:16], rv[19], "R8");
    end
    cyc(1'b1, 1'b0, 8'h00, 3'b000, 1'b0, "R9");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule